// File: doc/BRIEF.md
# Conjugate-Symmetric Spectral Product Accumulator

This block sits between a forward FFT and an inverse FFT in a convolution that runs in the frequency domain. Each cycle it can take one input spectrum vector and the weight spectrum that goes with it. It multiplies the two bin by bin and adds the products into a running spectrum. A caller feeds it every kernel position of a window (nine for a 3x3 kernel) for every input-channel block of one output-channel block. It marks the final term with a last flag. One cycle later the finished spectrum is presented to the inverse transform.

The time-domain signals are real, so their spectra are conjugate-symmetric. Only bins 0 through N/2 arrive, are multiplied and are held in accumulators. The block rebuilds the upper bins N/2+1 through N-1 at its output by conjugating their mirror bins, which needs no multiplier. Bias and normalisation are applied after the inverse transform, outside this block.

Top module: `conj_spec_accum`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and every output bin reads zero.
- R2: For each bin k with 0 < k < N/2, the term added is the complex product re = xr*wr - xi*wi, im = xr*wi + xi*wr. The product is arithmetically shifted right by FRAC and truncated to DW+GW bits. Bin k occupies bits [k*DW +: DW] of each input bus and bits [k*(DW+GW) +: DW+GW] of each output bus, in two's complement.
- R3: Bins 0 and N/2 are real-only. Their imaginary inputs have no effect, their term is xr*wr (scaled as in R2), and their output imaginary part is always zero.
- R4: For k from 1 to N/2-1, output bin N-k equals the complex conjugate of output bin k.
- R5: The result is the sum of every accepted term from the first term of a group through the term flagged last. A group can hold any number of terms from 1 upward, for example 9 kernel positions times any number of channel blocks.
- R6: out_valid is high for exactly the one cycle after a last term is accepted, and the result is readable in that cycle.
- R7: The term accepted after a last term starts a new sum. Nothing carries over from the previous group.
- R8: Cycles with in_valid low change nothing, whatever the data and last inputs carry.
- R9: Terms can be accepted on consecutive cycles, including a new group that starts right after a last term and groups of a single term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A term is presented this cycle |
| in_last | input | 1 | The presented term closes the group |
| x_re | input | (N/2+1)*DW | Input spectrum, real parts of bins 0..N/2 |
| x_im | input | (N/2+1)*DW | Input spectrum, imaginary parts of bins 0..N/2 |
| w_re | input | (N/2+1)*DW | Weight spectrum, real parts of bins 0..N/2 |
| w_im | input | (N/2+1)*DW | Weight spectrum, imaginary parts of bins 0..N/2 |
| out_valid | output | 1 | Completed spectrum present this cycle |
| y_re | output | N*(DW+GW) | Accumulated spectrum, real parts of bins 0..N-1 |
| y_im | output | N*(DW+GW) | Accumulated spectrum, imaginary parts of bins 0..N-1 |

## Verification
The spectra are built from random real 4-point vectors. The expected output is the transform of the direct circular convolution summed over the group, so a wrong sign in the complex product or a wrong mirror conjugate shows up as a mismatch. Groups of 9 and 18 terms test accumulation across kernel positions and channel blocks. Single-term groups sent back to back separate a correct restart from carry-over. Idle cycles that carry garbage data and a raised last flag, together with nonzero imaginary inputs on bins 0 and N/2, show whether ignored inputs leak into the sum.

// File: rtl/conj_spec_pkg.sv
// Shared definitions for the spectral accumulator.
// Assumes N is a power of two, at least 4.
package conj_spec_pkg;

    typedef enum logic {BIN_CPLX = 1'b0, BIN_REAL = 1'b1} bin_kind_e;

    // Bins 0 and N/2 of a real signal's spectrum carry no imaginary part.
    function automatic bin_kind_e kind_of(input int k, input int n);
        return (k == 0 || k == n / 2) ? BIN_REAL : BIN_CPLX;
    endfunction

endpackage

// File: rtl/spec_bin_mac.sv
// One bin of the accumulator: complex (or real-only) multiply, scale,
// truncate and accumulate. Assumes signed two's-complement operands and
// that restart is high on the first term of a group.
module spec_bin_mac
    import conj_spec_pkg::*;
#(
    parameter int        DW   = 16,
    parameter int        AW   = 24,
    parameter int        FRAC = 0,
    parameter bin_kind_e KIND = BIN_CPLX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 restart,
    input  logic signed [DW-1:0] xr,
    input  logic signed [DW-1:0] xi,
    input  logic signed [DW-1:0] wr,
    input  logic signed [DW-1:0] wi,
    output logic signed [AW-1:0] acc_re,
    output logic signed [AW-1:0] acc_im
);
    localparam int PW = (2 * DW + 1 > AW) ? 2 * DW + 1 : AW;

    logic signed [PW-1:0] xr_e, xi_e, wr_e, wi_e;
    logic signed [PW-1:0] prod_re, prod_im, shr_re, shr_im;
    logic signed [AW-1:0] term_re, term_im;

    assign xr_e = PW'(xr);
    assign xi_e = PW'(xi);
    assign wr_e = PW'(wr);
    assign wi_e = PW'(wi);

    generate
        if (KIND == BIN_REAL) begin : g_real
            logic edge_unused;
            assign edge_unused = ^{xi_e, wi_e};
            // Real-only bin: one multiply, imaginary inputs dropped.
            always_comb begin
                prod_re = xr_e * wr_e;
                prod_im = '0;
            end
        end else begin : g_cplx
            // Full complex product with four real multiplies.
            always_comb begin
                prod_re = xr_e * wr_e - xi_e * wi_e;
                prod_im = xr_e * wi_e + xi_e * wr_e;
            end
        end
    endgenerate

    assign shr_re  = prod_re >>> FRAC;
    assign shr_im  = prod_im >>> FRAC;
    assign term_re = shr_re[AW-1:0];
    assign term_im = shr_im[AW-1:0];

    // Running sum: restart drops the previous group's total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (take) begin
            acc_re <= (restart ? '0 : acc_re) + term_re;
            acc_im <= (restart ? '0 : acc_im) + term_im;
        end
    end

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(acc_re) && $stable(acc_im)));

endmodule

// File: rtl/spec_mirror.sv
// Expands bins 0..N/2 into a full N-bin spectrum by conjugate symmetry.
// Purely combinational. Assumes the input is a real signal's half spectrum.
module spec_mirror #(
    parameter int N  = 8,
    parameter int AW = 24
) (
    input  logic [(N/2+1)*AW-1:0] half_re,
    input  logic [(N/2+1)*AW-1:0] half_im,
    output logic [N*AW-1:0]       full_re,
    output logic [N*AW-1:0]       full_im
);
    generate
        for (genvar k = 0; k < N; k++) begin : g_bin
            if (k <= N / 2) begin : g_direct
                assign full_re[k*AW +: AW] = half_re[k*AW +: AW];
                assign full_im[k*AW +: AW] = half_im[k*AW +: AW];
            end else begin : g_conj
                assign full_re[k*AW +: AW] = half_re[(N-k)*AW +: AW];
                assign full_im[k*AW +: AW] = -half_im[(N-k)*AW +: AW];
            end
        end
    endgenerate

endmodule

// File: rtl/conj_spec_accum.sv
// Spectral product accumulator between a forward and an inverse FFT.
// Takes one half-spectrum term per cycle, sums it until the last flag, and
// presents the full conjugate-symmetric spectrum for one cycle afterwards.
// Assumes the caller sizes GW so that a group's sum does not overflow.
module conj_spec_accum
    import conj_spec_pkg::*;
#(
    parameter int N    = 8,
    parameter int DW   = 16,
    parameter int GW   = 8,
    parameter int FRAC = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic [(N/2+1)*DW-1:0]    x_re,
    input  logic [(N/2+1)*DW-1:0]    x_im,
    input  logic [(N/2+1)*DW-1:0]    w_re,
    input  logic [(N/2+1)*DW-1:0]    w_im,
    output logic                     out_valid,
    output logic [N*(DW+GW)-1:0]     y_re,
    output logic [N*(DW+GW)-1:0]     y_im
);
    localparam int NH = N / 2 + 1;
    localparam int AW = DW + GW;

    logic          first_q;
    logic [NH*AW-1:0] half_re, half_im;

    // Tracks whether the next accepted term opens a new group.
    always_ff @(posedge clk) begin
        if (!rst_n)        first_q <= 1'b1;
        else if (in_valid) first_q <= in_last;
    end

    // Output strobe: one cycle after the closing term.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid & in_last;
    end

    generate
        for (genvar k = 0; k < NH; k++) begin : g_mac
            spec_bin_mac #(
                .DW   (DW),
                .AW   (AW),
                .FRAC (FRAC),
                .KIND (kind_of(k, N))
            ) u_mac (
                .clk     (clk),
                .rst_n   (rst_n),
                .take    (in_valid),
                .restart (first_q),
                .xr      (x_re[k*DW +: DW]),
                .xi      (x_im[k*DW +: DW]),
                .wr      (w_re[k*DW +: DW]),
                .wi      (w_im[k*DW +: DW]),
                .acc_re  (half_re[k*AW +: AW]),
                .acc_im  (half_im[k*AW +: AW])
            );
        end
    endgenerate

    spec_mirror #(.N(N), .AW(AW)) u_mirror (
        .half_re (half_re),
        .half_im (half_im),
        .full_re (y_re),
        .full_im (y_im)
    );

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(in_valid && in_last) |=> !out_valid);

    a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !in_valid |=> ($stable(y_re) && $stable(y_im)));

    a_r9_valid_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last));

endmodule

// File: tb/sim_conj_spec_accum.sv
`timescale 1ns/1ps
module sim_conj_spec_accum;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int GW = 12;
    localparam int AW = DW + GW;
    localparam int NH = N / 2 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic [NH*DW-1:0] x_re = '0, x_im = '0, w_re = '0, w_im = '0;
    logic out_valid;
    logic [N*AW-1:0] y_re, y_im;

    int checks = 0;
    int fails = 0;
    int groups_sent = 0;
    int pulses_seen = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    conj_spec_accum #(.N(N), .DW(DW), .GW(GW), .FRAC(0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .x_re(x_re), .x_im(x_im), .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid), .y_re(y_re), .y_im(y_im)
    );

    function automatic int get_re(input int k);
        return int'($signed(y_re[k*AW +: AW]));
    endfunction
    function automatic int get_im(input int k);
        return int'($signed(y_im[k*AW +: AW]));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom_range(hi - lo, 0));
    endfunction

    // Drive one packed half spectrum of a real 4-point vector.
    task automatic put_spec(input int v[4], input bit is_w, input bit dirty);
        logic [NH*DW-1:0] re, im;
        re[0*DW +: DW] = DW'(v[0] + v[1] + v[2] + v[3]);
        re[1*DW +: DW] = DW'(v[0] - v[2]);
        re[2*DW +: DW] = DW'(v[0] - v[1] + v[2] - v[3]);
        im[1*DW +: DW] = DW'(v[3] - v[1]);
        im[0*DW +: DW] = dirty ? DW'(rnd(-100, 100)) : '0;
        im[2*DW +: DW] = dirty ? DW'(rnd(-100, 100)) : '0;
        if (is_w) begin w_re = re; w_im = im; end
        else      begin x_re = re; x_im = im; end
    endtask

    // Driver: sends a group, pushes the expected spectrum into the scoreboard.
    task automatic send_group(input int nterms, input int gap, input bit dirty);
        int acc[4] = '{0, 0, 0, 0};
        for (int t = 0; t < nterms; t++) begin
            int a[4], b[4];
            for (int i = 0; i < 4; i++) begin
                a[i] = rnd(-8, 7);
                b[i] = rnd(-8, 7);
            end
            for (int n = 0; n < 4; n++)
                for (int m = 0; m < 4; m++)
                    acc[n] += a[m] * b[(n - m + 4) % 4];
            @(negedge clk);
            put_spec(a, 1'b0, dirty);
            put_spec(b, 1'b1, dirty);
            in_valid = 1'b1;
            in_last  = (t == nterms - 1);
            if (t == nterms - 1) begin
                exp_q.push_back(acc[0] + acc[1] + acc[2] + acc[3]);
                exp_q.push_back(0);
                exp_q.push_back(acc[0] - acc[2]);
                exp_q.push_back(acc[3] - acc[1]);
                exp_q.push_back(acc[0] - acc[1] + acc[2] - acc[3]);
                exp_q.push_back(0);
                exp_q.push_back(acc[0] - acc[2]);
                exp_q.push_back(acc[1] - acc[3]);
                groups_sent++;
            end
            // R8: idle cycles carry garbage and a raised last flag.
            for (int g = 0; g < gap && t < nterms - 1; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b1;
                x_re = NH*DW'($urandom); x_im = NH*DW'($urandom);
                w_re = NH*DW'($urandom); w_im = NH*DW'($urandom);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a spectrum is presented.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            pulses_seen++;
            if (exp_q.size() < 8) begin
                check("R6 unexpected out_valid", 1, 0);
            end else begin
                int e[8];
                for (int i = 0; i < 8; i++) e[i] = exp_q.pop_front();
                check("R3 bin0 re", get_re(0), e[0]);
                check("R3 bin0 im", get_im(0), e[1]);
                check("R2 R5 bin1 re", get_re(1), e[2]);
                check("R2 R5 bin1 im", get_im(1), e[3]);
                check("R3 bin2 re", get_re(2), e[4]);
                check("R3 bin2 im", get_im(2), e[5]);
                check("R4 bin3 re", get_re(3), e[6]);
                check("R4 bin3 im", get_im(3), e[7]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 bin1 re after reset", get_re(1), 0);
        check("R1 bin0 re after reset", get_re(0), 0);

        send_group(9, 0, 1'b0);    // R5 one 3x3 window, one channel block
        idle(3);
        send_group(18, 0, 1'b0);   // R5 two channel blocks
        idle(2);
        send_group(9, 2, 1'b1);    // R8 gaps with garbage, R3 dirty imag
        idle(2);
        for (int i = 0; i < 5; i++) send_group(1, 0, 1'b1);  // R9 R7 single terms
        send_group(9, 0, 1'b0);    // R7 restart right after a last term
        send_group(9, 1, 1'b1);
        idle(2);
        for (int i = 0; i < 10; i++)
            send_group(rnd(1, 20), rnd(0, 2), ($urandom_range(1, 0) == 1));
        idle(6);

        check("R6 pulses per group", pulses_seen, groups_sent);
        check("R6 scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule